// File: doc/BRIEF.md
# Dual-Half NAND Sector Hamming Parity Engine

The engine sits beside the data path of a NAND flash controller and watches the bytes of a 512-byte sector as they move. The sector is split into two 256-byte halves. For each half it keeps 16 line parity bits and 6 column parity bits in single-error-correcting Hamming form. The host compares the stored code with a freshly computed one and corrects the data itself. This block only produces the code.

Control comes through mode writes of an 8-bit value:
- One value clears the parity state.
- One value arms accumulation.
- One value turns host reads into result readout. Three reads then deliver the six code bytes as three 16-bit words in a fixed, interleaved packing.
- Any other value parks the engine.

The engine counts the bytes that it accepts. That count selects the half, and also the line-parity position of each byte within its half.

Top module: `nand_ecc_engine`

## Requirements
- R1: A mode write of 0xF4 clears both halves' line and column parity and the byte counter, and leaves the engine idle (not accumulating).
- R2: After a mode write of 0xB4, each cycle with `byte_vld` high adds `byte_data` at the current count. Counts 0..255 go to half 0 and counts 256..511 go to half 1, and the count then advances by one.
- R3: For byte address a within a half (bits a[7:0]) and byte parity p:
  - For each k in 0..7, line parity bit 2k+1 accumulates p when a[k]=1, and bit 2k accumulates p when a[k]=0.
  - For each j in 0..2, column bit 2j+1 accumulates data bits whose index has bit j set, and column bit 2j accumulates the rest.
  - All codes are reported inverted, so an all-0xFF sector reads back as 0xFFFF in every word.
- R4: After a mode write of 0xD4, each `rd_req` returns one word on `rd_data`, with `rd_valid` high, in the cycle after the request. In {high byte, low byte} order:
  - word 0 = {half0 LP15..8, half0 LP7..0}
  - word 1 = {half1 LP7..0, half0 column}
  - word 2 = {half1 column, half1 LP15..8}
  - A column byte is {CP5..CP0, 2'b11}.
- R5: A fourth read returns word 0 again. Every mode write of 0xD4 restarts the readout at word 0.
- R6: Once 512 bytes have been accepted, further bytes are ignored until the next 0xF4 write. Bytes offered while the engine is not armed leave the parity unchanged.
- R7: In a cycle that carries a mode write:
  - a byte on `byte_vld` is not accumulated and does not advance the count;
  - a `rd_req` is not served.
- R8: A mode write of 0x94, or of any value other than 0xF4, 0xB4 and 0xD4, stops accumulation and readout. A `rd_req` outside readout mode gives no `rd_valid`, and the parity already held is kept.
- R9: After `rst`, the parity is clear, the engine is idle and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_val | input | 8 | Mode value written |
| byte_vld | input | 1 | A sector byte is on `byte_data` this cycle |
| byte_data | input | 8 | Sector byte being transferred |
| rd_req | input | 1 | Host read of the data register |
| rd_data | output | 16 | Result word (registered) |
| rd_valid | output | 1 | `rd_data` holds a result word from the previous cycle's request |

## Verification
The collision that matters is a mode write landing in the same cycle as a byte strobe. The bench provokes it twice:
- An arming write carries a byte with it.
- A clearing write arrives mid-sector while bytes are flowing.

In both cases a full sector follows. The result is judged against the parity of that sector alone, so an accepted stray byte, or a count that moved one position, shows up as wrong line-parity bits. A read strobe that coincides with a mode write is also covered, because readout must still begin at word 0.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam logic [7:0] MODE_ECC_CLEAR  = 8'hF4;
  localparam logic [7:0] MODE_ECC_ARM    = 8'hB4;
  localparam logic [7:0] MODE_ECC_RESULT = 8'hD4;
  localparam logic [7:0] MODE_DATA_XFER  = 8'h94;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_RESULT = 2'd2
  } ecc_state_e;
endpackage

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
  import nand_ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int CNT_W        = $clog2(SECTOR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_wr,
  input  logic [7:0]       mode_val,
  input  logic             byte_vld,
  input  logic             rd_req,
  output logic [CNT_W-1:0] cnt,
  output logic             acc_clr,
  output logic             acc_en,
  output logic             rd_accept,
  output logic             rd_start
);
  ecc_state_e state;
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(SECTOR_BYTES);

  always_comb begin
    acc_clr   = mode_wr && (mode_val == MODE_ECC_CLEAR);
    rd_start  = mode_wr && (mode_val == MODE_ECC_RESULT);
    acc_en    = (state == ST_ARMED) && byte_vld && !mode_wr && (cnt < CNT_LIMIT);
    rd_accept = (state == ST_RESULT) && rd_req && !mode_wr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (mode_wr) begin
      case (mode_val)
        MODE_ECC_CLEAR: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
        MODE_ECC_ARM:    state <= ST_ARMED;
        MODE_ECC_RESULT: state <= ST_RESULT;
        default:         state <= ST_IDLE;
      endcase
    end else if (acc_en) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_LIMIT);

  // R1
  clr_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && mode_val == MODE_ECC_CLEAR) |=> (cnt == '0));

  // R7
  collide_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (cnt == '0 || $stable(cnt)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_ARMED && !mode_wr) |=> $stable(cnt));
endmodule

// File: rtl/nand_ecc_parity.sv
module nand_ecc_parity #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8,
  parameter int LP_W   = 2 * ADDR_W,
  parameter int CP_W   = 2 * $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] data,
  output logic [LP_W-1:0]   lp,
  output logic [CP_W-1:0]   cp
);
  localparam int COL_BITS = CP_W / 2;

  logic              bpar;
  logic [LP_W-1:0]   lp_delta;
  logic [CP_W-1:0]   cp_delta;

  assign bpar = ^data;

  for (genvar k = 0; k < ADDR_W; k++) begin : g_line
    assign lp_delta[2*k+1] = addr[k] & bpar;
    assign lp_delta[2*k]   = ~addr[k] & bpar;
  end

  for (genvar j = 0; j < COL_BITS; j++) begin : g_col
    logic hi, lo;
    always_comb begin
      hi = 1'b0;
      lo = 1'b0;
      for (int b = 0; b < BYTE_W; b++) begin
        if (((b >> j) & 1) == 1) hi = hi ^ data[b];
        else                     lo = lo ^ data[b];
      end
    end
    assign cp_delta[2*j+1] = hi;
    assign cp_delta[2*j]   = lo;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lp <= '0;
      cp <= '0;
    end else if (en) begin
      lp <= lp ^ lp_delta;
      cp <= cp ^ cp_delta;
    end
  end

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> ($stable(lp) && $stable(cp)));

  // R3
  pair_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> ($countones(lp ^ $past(lp)) == ($past(bpar) ? ADDR_W : 0)));
endmodule

// File: rtl/nand_ecc_readout.sv
module nand_ecc_readout #(
  parameter int LP_W = 16,
  parameter int CP_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_start,
  input  logic            rd_accept,
  input  logic [LP_W-1:0] lp0,
  input  logic [CP_W-1:0] cp0,
  input  logic [LP_W-1:0] lp1,
  input  logic [CP_W-1:0] cp1,
  output logic [15:0]     rd_data,
  output logic            rd_valid
);
  localparam int PAD_W = 8 - CP_W;

  logic [LP_W-1:0] lp0_n, lp1_n;
  logic [7:0]      col0, col1;
  logic [15:0]     words [3];
  logic [1:0]      idx;

  always_comb begin
    lp0_n    = ~lp0;
    lp1_n    = ~lp1;
    col0     = {~cp0, {PAD_W{1'b1}}};
    col1     = {~cp1, {PAD_W{1'b1}}};
    words[0] = {lp0_n[15:8], lp0_n[7:0]};
    words[1] = {lp1_n[7:0], col0};
    words[2] = {col1, lp1_n[15:8]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= 2'd0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_accept;
      if (rd_start) begin
        idx <= 2'd0;
      end else if (rd_accept) begin
        rd_data <= words[idx];
        idx     <= (idx == 2'd2) ? 2'd0 : idx + 2'd1;
      end
    end
  end

  // R4
  valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_accept));

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    idx <= 2'd2);

  // R5
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    rd_start |=> (idx == 2'd0));
endmodule

// File: rtl/nand_ecc_engine.sv
module nand_ecc_engine
  import nand_ecc_pkg::*;
#(
  parameter int HALF_BYTES = 256,
  parameter int BYTE_W     = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mode_wr,
  input  logic [7:0]  mode_val,
  input  logic        byte_vld,
  input  logic [7:0]  byte_data,
  input  logic        rd_req,
  output logic [15:0] rd_data,
  output logic        rd_valid
);
  localparam int HALVES       = 2;
  localparam int SECTOR_BYTES = HALVES * HALF_BYTES;
  localparam int ADDR_W       = $clog2(HALF_BYTES);
  localparam int CNT_W        = $clog2(SECTOR_BYTES + 1);
  localparam int LP_W         = 2 * ADDR_W;
  localparam int CP_W         = 2 * $clog2(BYTE_W);

  logic [CNT_W-1:0] cnt;
  logic             acc_clr, acc_en, rd_accept, rd_start;
  logic [LP_W-1:0]  lp_q [HALVES];
  logic [CP_W-1:0]  cp_q [HALVES];

  nand_ecc_ctrl #(
    .SECTOR_BYTES (SECTOR_BYTES),
    .CNT_W        (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mode_wr   (mode_wr),
    .mode_val  (mode_val),
    .byte_vld  (byte_vld),
    .rd_req    (rd_req),
    .cnt       (cnt),
    .acc_clr   (acc_clr),
    .acc_en    (acc_en),
    .rd_accept (rd_accept),
    .rd_start  (rd_start)
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic half_en;
    assign half_en = acc_en && (cnt[ADDR_W] == 1'(h));

    nand_ecc_parity #(
      .ADDR_W (ADDR_W),
      .BYTE_W (BYTE_W),
      .LP_W   (LP_W),
      .CP_W   (CP_W)
    ) u_par (
      .clk  (clk),
      .rst  (rst),
      .clr  (acc_clr),
      .en   (half_en),
      .addr (cnt[ADDR_W-1:0]),
      .data (byte_data[BYTE_W-1:0]),
      .lp   (lp_q[h]),
      .cp   (cp_q[h])
    );
  end

  nand_ecc_readout #(
    .LP_W (LP_W),
    .CP_W (CP_W)
  ) u_rdout (
    .clk       (clk),
    .rst       (rst),
    .rd_start  (rd_start),
    .rd_accept (rd_accept),
    .lp0       (lp_q[0]),
    .cp0       (cp_q[0]),
    .lp1       (lp_q[1]),
    .cp1       (cp_q[1]),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  // R9
  rst_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !rd_valid);

  // R7
  collide_rd_chk: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> !rd_valid);
endmodule

// File: tb/nand_ecc_engine_bench.sv
`timescale 1ns/1ps
module nand_ecc_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_wr = 1'b0;
  logic [7:0]  mode_val = 8'h00;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic        rd_req = 1'b0;
  logic [15:0] rd_data;
  logic        rd_valid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] sector [512];

  always #2 clk = ~clk;

  nand_ecc_engine u_nand_ecc_engine (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_val(mode_val),
    .byte_vld(byte_vld), .byte_data(byte_data), .rd_req(rd_req),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // kind in [15:8], seed in [7:0]
  localparam logic [15:0] VEC [0:6] = '{
    16'h00FF, 16'h0000, 16'h0103, 16'h0237, 16'h0305, 16'h0329, 16'h02A5
  };

  function automatic logic [7:0] gen_byte(logic [7:0] kind, logic [7:0] seed, int i);
    case (kind)
      8'd0:    return seed;
      8'd1:    return 8'(i) + seed;
      8'd2:    return 8'(i * seed) ^ 8'(i >> 3);
      default: return (i == 256 + seed) ? 8'hFE : 8'hFF;
    endcase
  endfunction

  function automatic logic [47:0] model(int n);
    logic [15:0] lp [2];
    logic [5:0]  cp [2];
    logic [15:0] a, b;
    logic [7:0]  c0, c1;
    for (int h = 0; h < 2; h++) begin lp[h] = '0; cp[h] = '0; end
    for (int i = 0; i < n && i < 512; i++) begin
      int h = i / 256;
      int ad = i % 256;
      logic p = ^sector[i];
      for (int k = 0; k < 8; k++)
        if (((ad >> k) & 1) == 1) lp[h][2*k+1] ^= p; else lp[h][2*k] ^= p;
      for (int j = 0; j < 3; j++)
        for (int bt = 0; bt < 8; bt++)
          if (((bt >> j) & 1) == 1) cp[h][2*j+1] ^= sector[i][bt];
          else cp[h][2*j] ^= sector[i][bt];
    end
    a  = ~lp[0];
    b  = ~lp[1];
    c0 = {~cp[0], 2'b11};
    c1 = {~cp[1], 2'b11};
    return {a, b[7:0], c0, c1, b[15:8]};
  endfunction

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mode_write(logic [7:0] v);
    @(negedge clk);
    byte_vld = 1'b0; mode_wr = 1'b1; mode_val = v;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic push_byte(logic [7:0] b);
    @(negedge clk);
    byte_vld = 1'b1; byte_data = b;
  endtask

  task automatic bus_idle();
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic read_word(output logic [15:0] d, output logic v);
    @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic push_sector(int n);
    for (int i = 0; i < n; i++) push_byte(sector[i]);
    bus_idle();
  endtask

  task automatic check_result(logic [47:0] exp, string tag);
    logic [15:0] d; logic v;
    mode_write(8'hD4);
    for (int w = 0; w < 3; w++) begin
      read_word(d, v);
      check(v == 1'b1, tag, {15'd0, v}, 16'd1);
      check(d == exp[47-16*w -: 16], tag, d, exp[47-16*w -: 16]);
    end
  endtask

  task automatic fill(logic [15:0] vec);
    for (int i = 0; i < 512; i++) sector[i] = gen_byte(vec[15:8], vec[7:0], i);
  endtask

  task automatic start_sector();
    logic [15:0] d; logic v;
    mode_write(8'hF4);
    read_word(d, v);
    check(v == 1'b0, "R8 dummy read", {15'd0, v}, 16'd0);
    mode_write(8'hB4);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d; logic v;
    logic [47:0] exp, prev;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9: idle after reset, no read served
    read_word(d, v);
    check(v == 1'b0, "R9 reset idle", {15'd0, v}, 16'd0);
    check(d == 16'h0000, "R9 reset data", d, 16'h0000);
    // R9: cleared parity reads as inverted zero
    check_result({16'hFFFF, 16'hFFFF, 16'hFFFF}, "R9 cleared parity");

    // R2 R3 R4: vector table
    for (int t = 0; t < 7; t++) begin
      fill(VEC[t]);
      start_sector();
      push_sector(512);
      check_result(model(512), "R2 R3 R4 vector");
    end

    // R3: erased sector, constant expectation
    fill(16'h00FF);
    start_sector();
    push_sector(512);
    check_result({16'hFFFF, 16'hFFFF, 16'hFFFF}, "R3 erased");

    // R3: single flipped bit 0 at half1 byte 0x29
    fill(16'h0329);
    start_sector();
    push_sector(512);
    check_result({16'hFFFF, 16'h69FF, 16'hABA6}, "R3 flip");

    // R5: fourth read wraps to word 0
    read_word(d, v);
    check(v && d == 16'hFFFF, "R5 wrap", d, 16'hFFFF);

    // R6: bytes beyond 512 ignored
    fill(16'h0211);
    start_sector();
    for (int i = 0; i < 512; i++) push_byte(sector[i]);
    for (int i = 0; i < 9; i++) push_byte(8'(i * 7 + 1));
    bus_idle();
    exp = model(512);
    check_result(exp, "R6 overrun");

    // R8: data mode stops readout and accumulation, parity kept
    mode_write(8'h94);
    read_word(d, v);
    check(v == 1'b0, "R8 no read in data mode", {15'd0, v}, 16'd0);
    for (int i = 0; i < 20; i++) push_byte(8'(i + 3));
    bus_idle();
    mode_write(8'h95);
    for (int i = 0; i < 5; i++) push_byte(8'h01);
    bus_idle();
    check_result(exp, "R8 parity kept, R5 restart");

    // R7: byte in the arming cycle is not accumulated
    fill(16'h0142);
    mode_write(8'hF4);
    @(negedge clk);
    mode_wr = 1'b1; mode_val = 8'hB4; byte_vld = 1'b1; byte_data = 8'h5A;
    @(negedge clk);
    mode_wr = 1'b0; byte_vld = 1'b0;
    push_sector(512);
    check_result(model(512), "R7 arm collision");

    // R7 R1: clear wins over a byte mid-sector
    fill(16'h0277);
    start_sector();
    for (int i = 0; i < 100; i++) push_byte(8'(i ^ 8'h3C));
    @(negedge clk);
    mode_wr = 1'b1; mode_val = 8'hF4; byte_vld = 1'b1; byte_data = 8'h81;
    @(negedge clk);
    mode_wr = 1'b0; byte_vld = 1'b0;
    mode_write(8'hB4);
    push_sector(512);
    check_result(model(512), "R7 R1 clear collision");

    // R7: read in the same cycle as the readout mode write is not served
    prev = model(512);
    @(negedge clk);
    mode_wr = 1'b1; mode_val = 8'hD4; rd_req = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0; rd_req = 1'b0;
    check(rd_valid == 1'b0, "R7 read collision", {15'd0, rd_valid}, 16'd0);
    read_word(d, v);
    check(v && d == prev[47:32], "R7 read starts at word 0", d, prev[47:32]);

    // R2: short sector leaves half1 at cleared value
    fill(16'h0219);
    start_sector();
    push_sector(256);
    exp = model(256);
    check_result(exp, "R2 half sector");
    check(exp[31:24] == 8'hFF && exp[15:0] == 16'hFFFF, "R2 half1 clear",
          {exp[31:24], exp[7:0]}, 16'hFFFF);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule